// File: doc/BRIEF.md
# Accumulator Rounding Unit

This unit takes a 40-bit signed accumulator or product value and rounds it to its upper 24 bits. It returns a 40-bit result whose low 16 bits are zero. The upper 24 bits are the rounded integer part, still sign-extended across the 40-bit word. A mode bit in the 16-bit status word picks the rule used for each item. Convergent rounding sends an exact half to the even neighbour. Two's-complement rounding always sends an exact half upward.

Every accepted item also writes its result into one of two 40-bit accumulators. Bit 8 of the accompanying instruction word picks which one. The other accumulator keeps its value.

Input and output are valid/ready streams. An item is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid`/`out_value` in the next cycle, at the same edge that writes the accumulator. The output register holds its item until a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. So back-pressure on the output stalls the input directly, and no item is dropped or duplicated.

Top module: `accrnd_top`

## Requirements
- R1: After reset `out_valid` is low and both accumulators read zero.
- R2: When status bit 12 is 1 (two's-complement mode), the result is the value plus 0x8000 with bits 15:0 then cleared, so a fraction of exactly 0x8000 always rounds up.
- R3: When status bit 12 is 0 (convergent mode), a fraction of exactly 0x8000 rounds to the neighbour whose bit 16 is 0. If input bit 16 is 1 the value goes up, otherwise it goes down.
- R4: In either mode, a fraction below 0x8000 truncates, and a fraction above 0x8000 rounds up. This holds for positive and negative values.
- R5: Bits 15:0 of every output result are zero.
- R6: Rounding up from the positive limit wraps. 0x7F_FFFF_8000 in two's-complement mode gives 0x80_0000_0000, with no saturation.
- R7: The result of an item taken at one clock edge shows on `out_valid`/`out_value` after that edge, one cycle of latency.
- R8: Instruction bit 8 equal to 0 writes the result into accumulator 0, which is `acc_state[39:0]`. Bit 8 equal to 1 writes it into accumulator 1, which is `acc_state[79:40]`. The other accumulator is unchanged, and no accumulator changes without an accepted item.
- R9: While `out_valid` is high and `out_ready` is low, `out_value` stays stable and `in_ready` is low.
- R10: Status bits other than bit 12 and instruction bits other than bit 8 have no effect on the result or on which accumulator is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Unit can take an item this cycle |
| in_value | input | 40 | Signed value to round |
| in_status | input | 16 | Status word; bit 12 picks the rounding mode |
| in_opcode | input | 16 | Instruction word; bit 8 picks the accumulator |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 40 | Rounded result |
| acc_state | output | 80 | Accumulator 1 in the upper 40 bits, accumulator 0 in the lower 40 bits |

## Verification
The assertions assume that the consumer obeys the stream rules. They also assume that the input fields are meaningful only on cycles where `in_valid` is high; they make no claim about idle cycles. The bench drives `in_value`, `in_status` and `in_opcode` only from its send task. It holds them steady until the handshake completes and changes inputs and `out_ready` only just after a rising edge. `out_ready` is toggled pseudo-randomly, so stall cycles and back-to-back transfers are both exercised. The unused status and instruction bits are filled with noise to cover R10.

// File: rtl/accrnd_pkg.sv
package accrnd_pkg;
  typedef enum logic {
    RM_CONVERGENT = 1'b0,
    RM_TWOS       = 1'b1
  } round_mode_e;

  localparam int unsigned NUM_ACC = 2;
endpackage

// File: rtl/accrnd_core.sv
module accrnd_core
  import accrnd_pkg::*;
#(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned FRAC_W = 16
) (
  input  logic [ACC_W-1:0] value_i,
  input  round_mode_e      mode_i,
  output logic [ACC_W-1:0] rounded_o
);
  localparam logic [ACC_W:0] HALF_BIAS  = (ACC_W+1)'(1) << (FRAC_W - 1);
  localparam logic [ACC_W:0] UNDER_BIAS = HALF_BIAS - (ACC_W+1)'(1);

  logic [ACC_W:0] wide_val;
  logic [ACC_W:0] bias;
  logic [ACC_W:0] sum;

  always_comb begin
    wide_val = {value_i[ACC_W-1], value_i};
    if (mode_i == RM_TWOS || value_i[FRAC_W])
      bias = HALF_BIAS;
    else
      bias = UNDER_BIAS;
    sum       = wide_val + bias;
    rounded_o = {sum[ACC_W-1:FRAC_W], {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/accrnd_bank.sv
module accrnd_bank #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned N_ACC = 2,
  localparam int unsigned SEL_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [ACC_W-1:0]   wr_data,
  output logic [N_ACC*ACC_W-1:0] acc_flat
);
  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst)
        acc_q <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))
        acc_q <= wr_data;
    end
    assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/accrnd_outreg.sv
module accrnd_outreg #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid)
        dn_data <= up_data;
    end
  end
endmodule

// File: rtl/accrnd_top.sv
module accrnd_top
  import accrnd_pkg::*;
#(
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned OPC_W    = 16,
  parameter int unsigned MODE_BIT = 12,
  parameter int unsigned SEL_BIT  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ACC_W-1:0]         in_value,
  input  logic [STAT_W-1:0]        in_status,
  input  logic [OPC_W-1:0]         in_opcode,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ACC_W-1:0]         out_value,
  output logic [NUM_ACC*ACC_W-1:0] acc_state
);
  round_mode_e      mode;
  logic [ACC_W-1:0] rounded;
  logic             accept;

  assign mode   = round_mode_e'(in_status[MODE_BIT]);
  assign accept = in_valid && in_ready;

  accrnd_core #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_core (
    .value_i   (in_value),
    .mode_i    (mode),
    .rounded_o (rounded)
  );

  accrnd_outreg #(.W(ACC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (rounded),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_value)
  );

  accrnd_bank #(.ACC_W(ACC_W), .N_ACC(NUM_ACC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_sel   (in_opcode[SEL_BIT]),
    .wr_data  (rounded),
    .acc_flat (acc_state)
  );
endmodule

// File: rtl/accrnd_checker.sv
module accrnd_checker #(
  parameter int unsigned ACC_W   = 40,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned OPC_W   = 16,
  parameter int unsigned SEL_BIT = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [OPC_W-1:0]     in_opcode,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [ACC_W-1:0]     out_value,
  input logic [2*ACC_W-1:0]   acc_state
);
  // R5: fraction field of every result is clear
  p_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_value[FRAC_W-1:0] == '0);

  // R7: accepted item is visible one cycle later
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9: stalled result stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value)));

  // R9: stall propagates to the input
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: no write without an accepted item
  p_acc_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(acc_state));

  // R8: accumulator 0 receives the result when selected
  p_acc0_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_opcode[SEL_BIT]) |=>
      (acc_state[ACC_W-1:0] == out_value && $stable(acc_state[2*ACC_W-1:ACC_W])));

  // R8: accumulator 1 receives the result when selected
  p_acc1_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_opcode[SEL_BIT]) |=>
      (acc_state[2*ACC_W-1:ACC_W] == out_value && $stable(acc_state[ACC_W-1:0])));
endmodule

bind accrnd_top accrnd_checker #(
  .ACC_W(ACC_W), .FRAC_W(FRAC_W), .OPC_W(OPC_W), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .out_valid(out_valid), .out_ready(out_ready),
  .out_value(out_value), .acc_state(acc_state)
);

// File: tb/accrnd_top_test.sv
module accrnd_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_value = '0;
  logic [15:0] in_status = '0;
  logic [15:0] in_opcode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_value;
  logic [79:0] acc_state;

  int checks = 0;
  int fails  = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  typedef struct packed {
    logic [39:0] res;
    logic        sel;
  } exp_t;
  exp_t q[$];
  logic [39:0] acc_m0 = '0, acc_m1 = '0;

  always #5 clk = ~clk;

  accrnd_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_status(in_status), .in_opcode(in_opcode),
    .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value),
    .acc_state(acc_state)
  );

  function automatic logic [39:0] model(logic [39:0] v, bit twos);
    logic signed [39:0] up;
    logic [15:0] frac;
    bit bump;
    up   = $signed(v) >>> 16;
    frac = v[15:0];
    if (frac > 16'h8000) bump = 1;
    else if (frac < 16'h8000) bump = 0;
    else bump = twos || up[0];
    if (bump) up = up + 40'sd1;
    return 40'(up << 16);
  endfunction

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [39:0] v, bit twos, bit sel, bit noise);
    logic [15:0] st, op;
    st = noise ? 16'($urandom) : 16'h0;
    op = noise ? 16'($urandom) : 16'h0;
    st[12] = twos;
    op[8]  = sel;
    @(posedge clk); #1;
    in_valid = 1; in_value = v; in_status = st; in_opcode = op;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    q.push_back('{res: model(v, twos), sel: sel});
    @(posedge clk); #1;
    in_valid = 0;
    in_value = 40'($urandom);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          check("R7 unexpected output", {40'h0, out_value}, 80'h0);
        end else begin
          e = q.pop_front();
          if (e.sel) acc_m1 = e.res; else acc_m0 = e.res;
          check("R2-R6 result", {40'h0, out_value}, {40'h0, e.res});
          check("R8 accumulators", acc_state, {acc_m1, acc_m0});
        end
      end
    end
  end

  // output ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rand_ready) out_ready = ($urandom % 3) != 0;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 reset", {79'h0, out_valid}, 80'h0);
    check("R1 reset acc", acc_state, 80'h0);

    // R2/R3 halfway cases, R4 non-halfway, R6 wrap
    send(40'h00_0001_8000, 0, 0, 0); // R3 odd -> up
    send(40'h00_0002_8000, 0, 1, 0); // R3 even -> stays
    send(40'h00_0002_8000, 1, 0, 0); // R2 up
    send(40'hFF_FFFE_8000, 0, 1, 0); // R3 negative even
    send(40'hFF_FFFE_8000, 1, 1, 0); // R2 negative up
    send(40'h00_0004_7FFF, 0, 0, 0); // R4 truncate
    send(40'h00_0004_8001, 0, 0, 0); // R4 up
    send(40'hFF_FFF0_8001, 1, 1, 0); // R4 negative up
    send(40'h7F_FFFF_8000, 1, 0, 0); // R6 wrap
    repeat (2) @(negedge clk);
    check("R6 wrap acc0", {40'h0, acc_state[39:0]}, {40'h0, 40'h80_0000_0000});

    // R7 latency: item appears right after its edge
    @(posedge clk); #1;
    in_valid = 1; in_value = 40'h00_0010_0000; in_status = 16'h1000; in_opcode = 0;
    @(posedge clk); #1;
    in_valid = 0;
    q.push_back('{res: 40'h00_0010_0000, sel: 1'b0});
    @(negedge clk);
    check("R7 latency", {79'h0, out_valid}, {79'h0, 1'b1});

    // R9 stall
    @(posedge clk); #1 out_ready = 0;
    send(40'h00_0020_C000, 1, 1, 1);
    @(posedge clk); #1;
    in_valid = 1; in_value = 40'h12_3456_789A; in_status = 0; in_opcode = 0;
    repeat (3) begin
      @(negedge clk);
      check("R9 hold value", {40'h0, out_value}, {40'h0, 40'h00_0021_0000});
      check("R9 in_ready low", {79'h0, in_ready}, 80'h0);
    end
    @(posedge clk); #1 out_ready = 1;
    @(negedge clk);
    q.push_back('{res: model(40'h12_3456_789A, 0), sel: 1'b0});
    @(posedge clk); #1 in_valid = 0;

    // R10 noise on unused bits with random values, random back-pressure
    rand_ready = 1;
    for (int i = 0; i < 300; i++)
      send(40'($urandom) ^ {8'($urandom), 32'h0}, 1'($urandom), 1'($urandom), 1);
    rand_ready = 0;
    @(posedge clk); #1 out_ready = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 queue drained", {48'h0, 32'(q.size())}, 80'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule